// File: doc/BRIEF.md
# Duplicate-Tag Coherence Bank Controller

This block is the decision engine of one address-interleaved bank of a shared second-level cache that sits under eight private first-level caches. Rather than probing those caches, it keeps its own mirror of every first-level tag together with its MESI state. It classifies each incoming request into a single action, rewrites the mirrored state to match, and issues invalidations. The available actions are: answer from the shared level, send the request on to the first-level cache that owns the line, pass it to the off-chip protocol engine, or have memory fill the requester directly.

The shared level does not include the first-level contents. It receives only lines that the first-level caches evict, so it works as a victim store. A miss anywhere on chip is filled straight from memory into the requesting first-level cache. A line whose home is another node is passed to the protocol engine. The mirrored state for that line changes only when the engine reports that the transaction is complete. Until then, every further request to the same line is held off at the request port.

Top module: `cc_bank_ctrl`

## Requirements
- R1: After reset every mirrored entry and every victim entry is empty, all output valids are low, and an idle cycle (no accepted request, no completion) produces no output valid one cycle later.
- R2: A local read (req_op 0) where another core holds the line Exclusive or Modified gives action 1 (forward), with fwd_core naming that owner. The owner becomes Shared, the requester is recorded Shared, and no invalidation is issued.
- R3: A local read gives action 0 (reply from shared level) when the requester already holds the line, in which case its state is unchanged. It also gives action 0 when no other core owns the line and the victim store holds it, in which case the requester is recorded Shared if any other core holds the line and Exclusive otherwise.
- R4: A local read that no owner, no victim entry and no own copy can serve gives action 3 (memory), with mem_req_valid, mem_req_addr and mem_req_core. The requester is recorded Exclusive when no other core holds the line and Shared otherwise.
- R5: A local write (req_op 1) raises inv_valid with inv_mask set to exactly the other cores holding the line, records the requester Modified and the others Invalid, and drops a matching victim entry.
- R6: A local write gives action 1 toward the Exclusive/Modified owner if one exists. Otherwise it gives action 0 if the requester holds the line or the victim store has it. Otherwise it gives action 3.
- R7: A read or write whose home field (address bits [15:14]) differs from the bank's node gives action 2 (engine) and eng_req_valid with the address, core, write flag and the lowest free slot. Mirrored state for that line is left untouched until completion.
- R8: On eng_done_valid for a slot, a read completion records the requester Shared and demotes any Exclusive/Modified holder to Shared. A write completion records the requester Modified, invalidates all other holders and reports them on inv_valid/inv_mask. No response is produced.
- R9: A clean eviction (req_op 2) clears the evicting core's entry. A dirty eviction (req_op 3) also places the line in the victim store when the entry was Modified. An eviction whose tag does not match the core's entry is ignored. Evictions produce no output.
- R10: req_ready is low while eng_done_valid is high, while the request address equals a line pending at the engine, and for remote reads/writes while every engine slot is in use.
- R11: Each accepted read or write produces exactly one resp_valid pulse one cycle later. mem_req_valid accompanies only action 3 and eng_req_valid only action 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_core | input | 3 | Requesting core |
| req_op | input | 2 | 0 read, 1 write, 2 clean eviction, 3 dirty eviction |
| req_addr | input | 16 | Line address: [15:14] home node, [3:0] set |
| resp_valid | output | 1 | Decision valid |
| resp_action | output | 2 | 0 reply, 1 forward, 2 engine, 3 memory |
| resp_core | output | 3 | Core the decision belongs to |
| resp_addr | output | 16 | Line address of the decision |
| fwd_core | output | 3 | Owner targeted by a forward |
| inv_valid | output | 1 | Invalidation set valid |
| inv_mask | output | 8 | Cores to invalidate |
| mem_req_valid | output | 1 | Memory fill request |
| mem_req_addr | output | 16 | Line to fetch |
| mem_req_core | output | 3 | Core receiving the fill |
| eng_req_valid | output | 1 | Hand-off to the protocol engine |
| eng_req_addr | output | 16 | Line handed off |
| eng_req_core | output | 3 | Requesting core |
| eng_req_write | output | 1 | Hand-off is for ownership |
| eng_req_slot | output | 2 | Pending slot used |
| eng_done_valid | input | 1 | Engine completion |
| eng_done_slot | input | 2 | Slot being completed |

## Verification
The hardest situation to reach is a remote line whose mirrored state is changed by an engine completion while other requests to that same line are being held off. To get there, a read and then a write to one remote line are issued back to back, with a further request to that line pushed in the meantime and a request driven during the completion cycle itself. The write completion's invalidation mask then shows whether the earlier read completion was recorded. Filling all four engine slots with distinct remote lines covers the full-table stall. The random phase draws from a handful of sets and tags, so forwards, upgrades and victim hits happen often.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'd0,
    MESI_S = 2'd1,
    MESI_E = 2'd2,
    MESI_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    RQ_READ       = 2'd0,
    RQ_WRITE      = 2'd1,
    RQ_DROP_CLEAN = 2'd2,
    RQ_DROP_DIRTY = 2'd3
  } rq_e;

  typedef enum logic [1:0] {
    ACT_REPLY   = 2'd0,
    ACT_FORWARD = 2'd1,
    ACT_ENGINE  = 2'd2,
    ACT_MEMORY  = 2'd3
  } act_e;
endpackage

// File: rtl/cc_dup_tags.sv
module cc_dup_tags
  import cc_pkg::*;
#(
  parameter int NC    = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       lk_set,
  input  logic [TAG_W-1:0]       lk_tag,
  output logic [NC-1:0][1:0]     lk_state,
  input  logic [NC-1:0]          wr_en,
  input  logic [NC-1:0][1:0]     wr_state
);

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [TAG_W-1:0] tag_q [SETS];
    logic [1:0]       st_q  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) st_q[s] <= MESI_I;
      end else if (wr_en[c]) begin
        st_q[lk_set] <= wr_state[c];
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en[c]) tag_q[lk_set] <= lk_tag;
    end

    assign lk_state[c] = ((st_q[lk_set] != MESI_I) && (tag_q[lk_set] == lk_tag))
                         ? st_q[lk_set] : MESI_I;
  end

endmodule

// File: rtl/cc_victim_tags.sv
module cc_victim_tags #(
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inst_en,
  input  logic             clr_en
);

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (inst_en) begin
      vld_q[lk_set] <= 1'b1;
    end else if (clr_en) begin
      vld_q[lk_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[lk_set] <= lk_tag;
  end

  assign lk_hit = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);

endmodule

// File: rtl/cc_pend_table.sv
module cc_pend_table #(
  parameter int NP     = 4,
  parameter int ADDR_W = 16,
  parameter int CORE_W = 3,
  localparam int SLOT_W = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_busy,
  output logic              full,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [CORE_W-1:0] alloc_core,
  input  logic              alloc_wr,
  output logic [SLOT_W-1:0] alloc_slot,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_slot,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CORE_W-1:0] rd_core,
  output logic              rd_wr
);

  logic [NP-1:0]     vld_q;
  logic [NP-1:0]     wr_q;
  logic [ADDR_W-1:0] addr_q [NP];
  logic [CORE_W-1:0] core_q [NP];
  logic [NP-1:0]     match;

  for (genvar i = 0; i < NP; i++) begin : g_ent
    assign match[i] = vld_q[i] && (addr_q[i] == chk_addr);

    always_ff @(posedge clk) begin
      if (alloc_en && (alloc_slot == SLOT_W'(i))) begin
        addr_q[i] <= alloc_addr;
        core_q[i] <= alloc_core;
        wr_q[i]   <= alloc_wr;
      end
    end
  end

  always_comb begin
    alloc_slot = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_slot = SLOT_W'(i);
    end
  end

  assign chk_busy = |match;
  assign full     = &vld_q;
  assign rd_addr  = addr_q[free_slot];
  assign rd_core  = core_q[free_slot];
  assign rd_wr    = wr_q[free_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (free_en)  vld_q[free_slot]  <= 1'b0;
      if (alloc_en) vld_q[alloc_slot] <= 1'b1;
    end
  end

endmodule

// File: rtl/cc_decide.sv
module cc_decide
  import cc_pkg::*;
#(
  parameter int NC = 8,
  localparam int CORE_W = $clog2(NC)
) (
  input  logic              is_done,
  input  logic              done_wr,
  input  logic [1:0]        op,
  input  logic [CORE_W-1:0] core,
  input  logic [NC-1:0][1:0] peer,
  input  logic              l2_hit,
  input  logic              remote,
  output logic [1:0]        act,
  output logic [CORE_W-1:0] fwd,
  output logic [NC-1:0]     wr_en,
  output logic [NC-1:0][1:0] wr_st,
  output logic [NC-1:0]     inv,
  output logic              l2_inst,
  output logic              l2_clr,
  output logic              to_eng,
  output logic              give_resp
);

  logic [1:0]    own_st;
  logic [NC-1:0] hold;
  logic [NC-1:0] owner;

  always_comb begin
    own_st = peer[core];
    hold   = '0;
    owner  = '0;
    fwd    = '0;
    for (int c = NC - 1; c >= 0; c--) begin
      if (c != int'(core) && peer[c] != MESI_I) hold[c] = 1'b1;
      if (c != int'(core) && (peer[c] == MESI_E || peer[c] == MESI_M)) begin
        owner[c] = 1'b1;
        fwd      = CORE_W'(c);
      end
    end
  end

  always_comb begin
    act       = ACT_MEMORY;
    wr_en     = '0;
    wr_st     = '0;
    inv       = '0;
    l2_inst   = 1'b0;
    l2_clr    = 1'b0;
    to_eng    = 1'b0;
    give_resp = 1'b0;
    if (is_done) begin
      wr_en[core] = 1'b1;
      if (done_wr) begin
        wr_st[core] = MESI_M;
        wr_en       = wr_en | hold;
        inv         = hold;
      end else begin
        wr_st[core] = MESI_S;
        for (int c = 0; c < NC; c++) begin
          if (owner[c]) begin
            wr_en[c] = 1'b1;
            wr_st[c] = MESI_S;
          end
        end
      end
    end else begin
      case (rq_e'(op))
        RQ_READ: begin
          give_resp = 1'b1;
          if (remote) begin
            act    = ACT_ENGINE;
            to_eng = 1'b1;
          end else if (own_st != MESI_I) begin
            act = ACT_REPLY;
          end else if (|owner) begin
            act         = ACT_FORWARD;
            wr_en[core] = 1'b1;
            wr_st[core] = MESI_S;
            for (int c = 0; c < NC; c++) begin
              if (owner[c]) begin
                wr_en[c] = 1'b1;
                wr_st[c] = MESI_S;
              end
            end
          end else begin
            act         = l2_hit ? ACT_REPLY : ACT_MEMORY;
            wr_en[core] = 1'b1;
            wr_st[core] = (|hold) ? MESI_S : MESI_E;
          end
        end
        RQ_WRITE: begin
          give_resp = 1'b1;
          if (remote) begin
            act    = ACT_ENGINE;
            to_eng = 1'b1;
          end else begin
            wr_en       = hold;
            wr_en[core] = 1'b1;
            wr_st[core] = MESI_M;
            inv         = hold;
            l2_clr      = l2_hit;
            if (|owner)                            act = ACT_FORWARD;
            else if (own_st != MESI_I || l2_hit)   act = ACT_REPLY;
            else                                   act = ACT_MEMORY;
          end
        end
        RQ_DROP_CLEAN: begin
          if (own_st != MESI_I) wr_en[core] = 1'b1;
        end
        default: begin
          if (own_st != MESI_I) wr_en[core] = 1'b1;
          l2_inst = (own_st == MESI_M);
        end
      endcase
    end
  end

endmodule

// File: rtl/cc_bank_ctrl.sv
module cc_bank_ctrl
  import cc_pkg::*;
#(
  parameter int NC      = 8,
  parameter int SETS    = 16,
  parameter int ADDR_W  = 16,
  parameter int HOME_W  = 2,
  parameter int NODE_ID = 0,
  parameter int NP      = 4,
  localparam int CORE_W = $clog2(NC),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int SLOT_W = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [1:0]        resp_action,
  output logic [CORE_W-1:0] resp_core,
  output logic [ADDR_W-1:0] resp_addr,
  output logic [CORE_W-1:0] fwd_core,
  output logic              inv_valid,
  output logic [NC-1:0]     inv_mask,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [CORE_W-1:0] mem_req_core,
  output logic              eng_req_valid,
  output logic [ADDR_W-1:0] eng_req_addr,
  output logic [CORE_W-1:0] eng_req_core,
  output logic              eng_req_write,
  output logic [SLOT_W-1:0] eng_req_slot,
  input  logic              eng_done_valid,
  input  logic [SLOT_W-1:0] eng_done_slot
);

  logic              remote, is_rw, busy, full, acc;
  logic [SLOT_W-1:0] alloc_slot;
  logic [ADDR_W-1:0] pd_addr, lk_addr;
  logic [CORE_W-1:0] pd_core, dec_core;
  logic              pd_wr;
  logic [NC-1:0][1:0] peer;
  logic              l2_hit;
  logic [1:0]        dec_act;
  logic [CORE_W-1:0] dec_fwd;
  logic [NC-1:0]     dec_wr_en, dt_wr_en, dec_inv;
  logic [NC-1:0][1:0] dec_wr_st;
  logic              dec_l2_inst, dec_l2_clr, dec_to_eng, dec_give;

  assign remote    = req_addr[ADDR_W-1 -: HOME_W] != HOME_W'(NODE_ID);
  assign is_rw     = ~req_op[1];
  assign req_ready = !eng_done_valid && !busy && !(remote && is_rw && full);
  assign acc       = req_valid && req_ready;
  assign lk_addr   = eng_done_valid ? pd_addr : req_addr;
  assign dec_core  = eng_done_valid ? pd_core : req_core;
  assign dt_wr_en  = (acc || eng_done_valid) ? dec_wr_en : '0;

  cc_pend_table #(.NP(NP), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .chk_addr(req_addr), .chk_busy(busy), .full(full),
    .alloc_en(acc && dec_to_eng), .alloc_addr(req_addr), .alloc_core(req_core),
    .alloc_wr(req_op[0]), .alloc_slot(alloc_slot),
    .free_en(eng_done_valid), .free_slot(eng_done_slot),
    .rd_addr(pd_addr), .rd_core(pd_core), .rd_wr(pd_wr)
  );

  cc_dup_tags #(.NC(NC), .SETS(SETS), .TAG_W(TAG_W)) u_dup (
    .clk(clk), .rst_n(rst_n),
    .lk_set(lk_addr[SET_W-1:0]), .lk_tag(lk_addr[ADDR_W-1:SET_W]),
    .lk_state(peer), .wr_en(dt_wr_en), .wr_state(dec_wr_st)
  );

  cc_victim_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_vic (
    .clk(clk), .rst_n(rst_n),
    .lk_set(lk_addr[SET_W-1:0]), .lk_tag(lk_addr[ADDR_W-1:SET_W]),
    .lk_hit(l2_hit),
    .inst_en(acc && dec_l2_inst), .clr_en(acc && dec_l2_clr)
  );

  cc_decide #(.NC(NC)) u_dec (
    .is_done(eng_done_valid), .done_wr(pd_wr), .op(req_op), .core(dec_core),
    .peer(peer), .l2_hit(l2_hit), .remote(remote),
    .act(dec_act), .fwd(dec_fwd), .wr_en(dec_wr_en), .wr_st(dec_wr_st),
    .inv(dec_inv), .l2_inst(dec_l2_inst), .l2_clr(dec_l2_clr),
    .to_eng(dec_to_eng), .give_resp(dec_give)
  );

  // next-state for the output stage
  logic resp_v_d, inv_v_d, mem_v_d, eng_v_d;
  logic resp_v_q, inv_v_q, mem_v_q, eng_v_q;
  logic [1:0]        act_q;
  logic [CORE_W-1:0] core_q, fwd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              wr_q;
  logic [NC-1:0]     inv_q;

  always_comb begin
    resp_v_d = acc && dec_give;
    inv_v_d  = (acc || eng_done_valid) && (|dec_inv);
    mem_v_d  = resp_v_d && (dec_act == ACT_MEMORY);
    eng_v_d  = acc && dec_to_eng;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_v_q <= 1'b0;
      inv_v_q  <= 1'b0;
      mem_v_q  <= 1'b0;
      eng_v_q  <= 1'b0;
    end else begin
      resp_v_q <= resp_v_d;
      inv_v_q  <= inv_v_d;
      mem_v_q  <= mem_v_d;
      eng_v_q  <= eng_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (resp_v_d) begin
      act_q  <= dec_act;
      core_q <= req_core;
      addr_q <= req_addr;
      fwd_q  <= dec_fwd;
      slot_q <= alloc_slot;
      wr_q   <= req_op[0];
    end
    if (inv_v_d) inv_q <= dec_inv;
  end

  assign resp_valid    = resp_v_q;
  assign resp_action   = act_q;
  assign resp_core     = core_q;
  assign resp_addr     = addr_q;
  assign fwd_core      = fwd_q;
  assign inv_valid     = inv_v_q;
  assign inv_mask      = inv_q;
  assign mem_req_valid = mem_v_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_core  = core_q;
  assign eng_req_valid = eng_v_q;
  assign eng_req_addr  = addr_q;
  assign eng_req_core  = core_q;
  assign eng_req_write = wr_q;
  assign eng_req_slot  = slot_q;

endmodule

// File: rtl/cc_bank_ctrl_chk.sv
module cc_bank_ctrl_chk #(
  parameter int NC = 8,
  localparam int CORE_W = $clog2(NC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              eng_done_valid,
  input logic              resp_valid,
  input logic [1:0]        resp_action,
  input logic [CORE_W-1:0] resp_core,
  input logic              inv_valid,
  input logic [NC-1:0]     inv_mask,
  input logic              mem_req_valid,
  input logic              eng_req_valid
);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_valid) && !$past(eng_done_valid)) |-> (!resp_valid && !inv_valid));

  p_read_no_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_op) == 2'd0) |-> !inv_valid);

  p_inv_not_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && inv_valid) |-> !inv_mask[resp_core]);

  p_eng_with_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_valid |-> (resp_valid && resp_action == 2'd2));

  p_done_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done_valid |-> !req_ready);

  p_mem_with_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (resp_valid && resp_action == 2'd3));

  p_resp_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid) && $past(req_ready)));

endmodule

bind cc_bank_ctrl cc_bank_ctrl_chk #(.NC(NC)) u_chk (.*);

// File: tb/cc_bank_ctrl_tb_top.sv
`timescale 1ns/100ps
module cc_bank_ctrl_tb_top;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_core;
  logic [1:0]  req_op;
  logic [15:0] req_addr;
  logic        resp_valid;
  logic [1:0]  resp_action;
  logic [2:0]  resp_core, fwd_core;
  logic [15:0] resp_addr;
  logic        inv_valid;
  logic [7:0]  inv_mask;
  logic        mem_req_valid;
  logic [15:0] mem_req_addr;
  logic [2:0]  mem_req_core;
  logic        eng_req_valid;
  logic [15:0] eng_req_addr;
  logic [2:0]  eng_req_core;
  logic        eng_req_write;
  logic [1:0]  eng_req_slot;
  logic        eng_done_valid;
  logic [1:0]  eng_done_slot;

  cc_bank_ctrl dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // reference model state
  int          m_st [8][16];
  logic [11:0] m_tg [8][16];
  bit          l2v [16];
  logic [11:0] l2t [16];
  bit          pv [4];
  logic [15:0] pa [4];
  int          pc [4];
  bit          pw [4];
  int          e_slot;

  task automatic check(input string tg, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tg, got, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int home, input int mid, input int set);
    return {home[1:0], mid[9:0], set[3:0]};
  endfunction

  function automatic int pst(input int c, input logic [15:0] a);
    if (m_st[c][a[3:0]] != 0 && m_tg[c][a[3:0]] == a[15:4]) return m_st[c][a[3:0]];
    return 0;
  endfunction

  function automatic bit m_ready(input int op, input logic [15:0] a);
    bit busy = 0, full = 1;
    for (int i = 0; i < 4; i++) begin
      if (pv[i] && pa[i] == a) busy = 1;
      if (!pv[i]) full = 0;
    end
    return !busy && !(a[15:14] != 2'd0 && op < 2 && full);
  endfunction

  task automatic set_st(input int c, input logic [15:0] a, input int st);
    m_st[c][a[3:0]] = st;
    m_tg[c][a[3:0]] = a[15:4];
  endtask

  task automatic alloc(input int c, input logic [15:0] a, input bit w);
    e_slot = -1;
    for (int i = 3; i >= 0; i--) if (!pv[i]) e_slot = i;
    pv[e_slot] = 1; pa[e_slot] = a; pc[e_slot] = c; pw[e_slot] = w;
  endtask

  task automatic model_req(input int c, input int op, input logic [15:0] a,
                           output bit er, output int ea, output int ef,
                           output bit eiv, output logic [7:0] eim, output string tg);
    int s = int'(a[3:0]);
    bit rem = (a[15:14] != 2'd0);
    int own = pst(c, a);
    logic [7:0] hold = '0;
    int ownr = -1;
    bit l2h = l2v[s] && (l2t[s] == a[15:4]);
    for (int k = 7; k >= 0; k--) begin
      if (k != c && pst(k, a) != 0) hold[k] = 1'b1;
      if (k != c && pst(k, a) >= 2) ownr = k;
    end
    er = 0; ea = 0; ef = 0; eiv = 0; eim = '0; tg = "R9";
    case (op)
      0: begin
        er = 1;
        if (rem) begin ea = 2; tg = "R7"; alloc(c, a, 0); end
        else if (own != 0) begin ea = 0; tg = "R3"; end
        else if (ownr >= 0) begin
          ea = 1; ef = ownr; tg = "R2";
          m_st[ownr][s] = 1; set_st(c, a, 1);
        end else begin
          ea = l2h ? 0 : 3; tg = l2h ? "R3" : "R4";
          set_st(c, a, (hold != 0) ? 1 : 2);
        end
      end
      1: begin
        er = 1;
        if (rem) begin ea = 2; tg = "R7"; alloc(c, a, 1); end
        else begin
          tg = "R6";
          if (ownr >= 0) begin ea = 1; ef = ownr; end
          else if (own != 0 || l2h) ea = 0;
          else ea = 3;
          for (int k = 0; k < 8; k++) if (hold[k]) m_st[k][s] = 0;
          set_st(c, a, 3);
          eiv = (hold != 0); eim = hold;
          if (l2h) l2v[s] = 0;
        end
      end
      default: begin
        if (own != 0) begin
          m_st[c][s] = 0;
          if (op == 3 && own == 3) begin l2v[s] = 1; l2t[s] = a[15:4]; end
        end
      end
    endcase
  endtask

  task automatic compare(input int c, input logic [15:0] a, input bit er, input int ea,
                         input int ef, input bit eiv, input logic [7:0] eim, input string tg);
    check({tg, " resp_valid"}, resp_valid, er);
    if (er) begin
      check({tg, " action"}, resp_action, ea);
      check("R11 resp_core", resp_core, c);
      check("R11 resp_addr", resp_addr, a);
      if (ea == 1) check("R2 fwd_core", fwd_core, ef);
      if (ea == 3) check("R4 mem_req_addr", mem_req_addr, a);
      if (ea == 2) check("R7 eng_req_slot", eng_req_slot, e_slot);
    end
    check("R11 mem_req_valid", mem_req_valid, int'(er && ea == 3));
    check("R11 eng_req_valid", eng_req_valid, int'(er && ea == 2));
    check({tg, " inv_valid"}, inv_valid, eiv);
    if (eiv) check("R5 inv_mask", inv_mask, eim);
  endtask

  task automatic do_req(input int c, input int op, input logic [15:0] a);
    bit er, eiv, rdy;
    int ea, ef;
    logic [7:0] eim;
    string tg;
    @(negedge clk);
    req_valid = 1'b1; req_core = c[2:0]; req_op = op[1:0]; req_addr = a;
    eng_done_valid = 1'b0;
    #1;
    rdy = m_ready(op, a);
    check("R10 req_ready", req_ready, rdy);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (rdy) begin
      model_req(c, op, a, er, ea, ef, eiv, eim, tg);
      compare(c, a, er, ea, ef, eiv, eim, tg);
    end else begin
      check("R10 stalled resp_valid", resp_valid, 0);
      check("R10 stalled inv_valid", inv_valid, 0);
    end
  endtask

  task automatic do_done(input int slot, input bit with_req);
    logic [7:0] hold = '0;
    int c = pc[slot];
    int s = int'(pa[slot][3:0]);
    @(negedge clk);
    eng_done_valid = 1'b1; eng_done_slot = slot[1:0];
    req_valid = with_req; req_core = 3'd1; req_op = 2'd1; req_addr = mk(0, 5, 9);
    #1;
    check("R10 ready low at completion", req_ready, 0);
    @(posedge clk); #1;
    eng_done_valid = 1'b0; req_valid = 1'b0;
    for (int k = 0; k < 8; k++) if (k != c && pst(k, pa[slot]) != 0) hold[k] = 1'b1;
    if (pw[slot]) begin
      for (int k = 0; k < 8; k++) if (hold[k]) m_st[k][s] = 0;
      set_st(c, pa[slot], 3);
    end else begin
      for (int k = 0; k < 8; k++) if (k != c && pst(k, pa[slot]) >= 2) m_st[k][s] = 1;
      set_st(c, pa[slot], 1);
    end
    pv[slot] = 0;
    check("R8 no resp on completion", resp_valid, 0);
    check("R8 completion inv_valid", inv_valid, int'(pw[slot] && hold != 0));
    if (pw[slot] && hold != 0) check("R8 completion inv_mask", inv_mask, hold);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int c = 0; c < 8; c++) for (int s = 0; s < 16; s++) begin m_st[c][s] = 0; m_tg[c][s] = '0; end
    for (int s = 0; s < 16; s++) begin l2v[s] = 0; l2t[s] = '0; end
    for (int i = 0; i < 4; i++) begin pv[i] = 0; pa[i] = '0; pc[i] = 0; pw[i] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_op = '0; req_addr = '0;
    eng_done_valid = 1'b0; eng_done_slot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 resp_valid after reset", resp_valid, 0);
    check("R1 inv_valid after reset", inv_valid, 0);
    check("R1 mem_req_valid after reset", mem_req_valid, 0);
    check("R1 eng_req_valid after reset", eng_req_valid, 0);
    repeat (2) @(posedge clk);
    #1 check("R1 idle stays quiet", resp_valid, 0);

    // directed: sharing and ownership on one local line
    do_req(0, 0, mk(0, 1, 1));             // R4: memory, Exclusive
    check("R4 literal memory", resp_action, 3);
    do_req(1, 0, mk(0, 1, 1));             // R2: forward to core 0
    check("R2 literal forward", fwd_core, 0);
    do_req(2, 0, mk(0, 1, 1));             // R4: sharers, no owner
    do_req(3, 1, mk(0, 1, 1));             // R5/R6: invalidate 0,1,2
    check("R5 literal mask", inv_mask, 8'h07);
    do_req(4, 0, mk(0, 1, 1));             // R2: forward to core 3
    do_req(3, 3, mk(0, 1, 1));             // R9: dirty drop of a Shared line
    do_req(0, 2, mk(0, 7, 1));             // R9: non-matching drop ignored
    do_req(5, 1, mk(0, 2, 2));             // R6: memory
    do_req(5, 3, mk(0, 2, 2));             // R9: victim install
    do_req(6, 0, mk(0, 2, 2));             // R3: victim reply, Exclusive
    check("R3 literal reply", resp_action, 0);
    do_req(6, 0, mk(0, 2, 2));             // R3: own copy
    do_req(6, 1, mk(0, 2, 2));             // R6: upgrade reply
    do_req(7, 0, mk(0, 2, 2));             // R2: forward to core 6

    // directed: remote lines and engine stalls
    do_req(7, 0, mk(1, 3, 4));             // R7: engine slot 0
    do_req(7, 0, mk(1, 3, 4));             // R10: same line stalled
    do_req(0, 1, mk(1, 3, 4));             // R10: other core stalled
    do_done(0, 1'b1);                       // R8: read completion
    do_req(1, 1, mk(1, 3, 4));             // R7: engine write
    do_done(0, 1'b0);                       // R8: mask names core 7
    do_req(0, 0, mk(1, 4, 5));
    do_req(0, 0, mk(2, 4, 5));
    do_req(0, 0, mk(3, 4, 5));
    do_req(0, 0, mk(1, 4, 6));             // table now full
    do_req(1, 1, mk(2, 9, 7));             // R10: full stall
    do_req(1, 0, mk(0, 9, 7));             // local still accepted
    for (int i = 0; i < 4; i++) do_done(i, 1'b0);

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      int np = 0;
      for (int i = 0; i < 4; i++) if (pv[i]) np++;
      if (np > 0 && ($urandom % 4) == 0) begin
        int pick = int'($urandom % 4);
        while (!pv[pick]) pick = (pick + 1) % 4;
        do_done(pick, ($urandom % 2) == 1);
      end else begin
        int r = int'($urandom % 100);
        int op = (r < 35) ? 0 : (r < 65) ? 1 : (r < 80) ? 2 : 3;
        int home = (($urandom % 100) < 15) ? int'(1 + $urandom % 3) : 0;
        do_req(int'($urandom % 8), op, mk(home, int'($urandom % 3), int'($urandom % 4)));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule